// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one branch operation per accepted transfer for a 32-bit fixed-width RISC core that has a condition register, a count register and a link register. An upstream decoder hands it an already decoded branch: a two-bit kind code, the absolute-address and link bits, the five-bit option field and the five-bit condition-bit selector, and a word displacement. Alongside the operation come the current instruction address, the condition register, and two special-register operands. One carries a link or target address. The other carries the count register.

For each operation the unit decides whether control leaves sequential flow and computes the next fetch address. It also computes the return address that a linking branch must write into the link register. Results are held in one output register stage behind a valid/ready handshake, so the latency is one cycle. A result stays on the outputs until the consumer takes it. Writing back a decremented counter is left to the surrounding pipeline.

Top module: `branchUnit`

## Requirements
- R1: `inReady` is high whenever the output stage is empty or its result is taken in the same cycle. An operation accepted at a clock edge (`inValid` and `inReady`) appears with `outValid` high right after that edge. While `outValid` is high and `outReady` is low, every output holds its value.
- R2: Kind 0 (unconditional) always branches. The offset is `dispWord` (24 bits) sign-extended and multiplied by 4. With `aaBit`=1 the target is the offset alone; with `aaBit`=0 the target is the aligned instruction address plus the offset.
- R3: Kind 1 (conditional, displacement) uses only `dispWord[13:0]`, sign-extended and multiplied by 4, and forms its target the same way as R2 under `aaBit`. `dispWord[23:14]` has no effect for this kind.
- R4: For kinds 1, 2 and 3, `biField`=n selects `condReg[31-n]` (n=0 is the most significant bit). When `boField[4]`=0 the branch requires that bit to equal `boField[3]`. When `boField[4]`=1 the bit is not tested.
- R5: For kinds 1, 2 and 3 with `boField[2]`=0, the count `sprCount`-1 (modulo 2^32) is tested. `boField[1]`=1 requires it to be zero, and `boField[1]`=0 requires it to be non-zero. With `boField[2]`=1 the count has no effect.
- R6: Kinds 2 (via link register) and 3 (via target register) take the target from `sprTarget` with its two low bits cleared. `aaBit` and `dispWord` have no effect for these kinds.
- R7: When the tests of R4 and R5 fail, `nextAddr` is the aligned instruction address plus 4.
- R8: `nextTaken` is high exactly when `nextAddr` differs from the aligned instruction address plus 4. This includes a satisfied branch whose target equals the sequential address, which gives a low `nextTaken`.
- R9: `linkWrite` equals the accepted `lkBit`. `linkAddr` is the aligned instruction address plus 4 whether or not the branch is taken.
- R10: The two low bits of `instAddr` are ignored, so `nextAddr` and `linkAddr` always have their two low bits at zero.
- R11: After reset `outValid`, `nextTaken` and `linkWrite` are low. `nextTaken` and `linkWrite` stay low whenever `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can take an operation this cycle |
| opKind | input | 2 | 0 unconditional, 1 conditional, 2 via link register, 3 via target register |
| aaBit | input | 1 | Absolute target select (kinds 0 and 1) |
| lkBit | input | 1 | Write link register |
| boField | input | 5 | Branch options |
| biField | input | 5 | Condition-bit selector |
| dispWord | input | 24 | Signed word displacement |
| instAddr | input | 32 | Address of the branch instruction |
| condReg | input | 32 | Condition register |
| sprTarget | input | 32 | Link or target register value |
| sprCount | input | 32 | Count register value |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| nextAddr | output | 32 | Resolved next fetch address |
| nextTaken | output | 1 | Next address leaves sequential flow |
| linkAddr | output | 32 | Return address |
| linkWrite | output | 1 | Link register must be written |

## Verification
The bound checker checks the handshake on every cycle: an accepted operation becomes a valid result, and a stalled result holds. It also checks every cycle that the taken flag agrees with a comparison of next and return addresses, that both addresses are word aligned, that the flags are low while idle, and that the link flag and return address follow the accepted operation. Whether the target arithmetic, the condition-bit selection and the counter tests pick the right address can only be shown by the bench. Its scoreboard compares every result against an independent model over the option encodings, the boundary counts 0 and 1, the end selector values, negative displacements and targets that land on the sequential address, under both free-flowing and stalled output.

// File: rtl/brPkg.sv
package brPkg;
  typedef enum logic [1:0] {
    KIND_UNCOND    = 2'd0,
    KIND_COND      = 2'd1,
    KIND_LINKREG   = 2'd2,
    KIND_TARGETREG = 2'd3
  } brKind_t;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_REL = 2'd1,
    SRC_ABS = 2'd2,
    SRC_REG = 2'd3
  } brSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;   // capture a new result
    logic   drain;  // result consumed, nothing new: clear flags
    brSrc_t src;    // where the next address comes from
  } brStrobe_t;

  localparam int BO_W = 5;
endpackage

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
#(
  parameter int CR_W  = 32,
  parameter int CTR_W = 32,
  parameter int BI_W  = $clog2(CR_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  brKind_t          kind,
  input  logic             aaBit,
  input  logic [BO_W-1:0]  boField,
  input  logic [BI_W-1:0]  biField,
  input  logic [CR_W-1:0]  condReg,
  input  logic [CTR_W-1:0] sprCount,
  output logic             outValid,
  input  logic             outReady,
  output brStrobe_t        strobe
);
  localparam logic [BI_W-1:0] TOP_IDX = BI_W'(CR_W - 1);

  logic [CTR_W-1:0] ctrNext;
  logic             ctrZero;
  logic             ctrOk;
  logic [BI_W-1:0]  crIdx;
  logic             crBit;
  logic             condOk;
  logic             pass;
  logic             validQ;

  // counter test (option bit 2 clear enables it, bit 1 picks zero / non-zero)
  assign ctrNext = sprCount - CTR_W'(1);
  assign ctrZero = (ctrNext == '0);
  assign ctrOk   = boField[2] | (ctrZero == boField[1]);

  // condition-bit test (bit 0 of the selector is the most significant bit)
  assign crIdx  = TOP_IDX - biField;
  assign crBit  = condReg[crIdx];
  assign condOk = boField[4] | (crBit == boField[3]);

  assign pass = (kind == KIND_UNCOND) | (ctrOk & condOk);

  always_comb begin
    if (!pass) begin
      strobe.src = SRC_SEQ;
    end else begin
      unique case (kind)
        KIND_UNCOND, KIND_COND: strobe.src = aaBit ? SRC_ABS : SRC_REL;
        default:                strobe.src = SRC_REG;
      endcase
    end
  end

  assign inReady      = ~validQ | outReady;
  assign strobe.load  = inValid & inReady;
  assign strobe.drain = validQ & outReady & ~strobe.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  assign outValid = validQ;
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobe,
  input  brKind_t           kind,
  input  logic              lkBit,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [LONG_W-1:0] dispWord,
  input  logic [ADDR_W-1:0] sprTarget,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              nextTaken,
  output logic [ADDR_W-1:0] linkAddr,
  output logic              linkWrite
);
  localparam int LONG_PAD  = ADDR_W - LONG_W - 2;
  localparam int SHORT_PAD = ADDR_W - SHORT_W - 2;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(4);

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] longOff;
  logic [ADDR_W-1:0] shortOff;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] relAddr;
  logic [ADDR_W-1:0] regAddr;
  logic [ADDR_W-1:0] resolved;

  assign baseAddr = instAddr & ALIGN_MASK;
  assign seqAddr  = baseAddr + WORD_STEP;

  assign longOff  = {{LONG_PAD{dispWord[LONG_W-1]}}, dispWord, 2'b00};
  assign shortOff = {{SHORT_PAD{dispWord[SHORT_W-1]}}, dispWord[SHORT_W-1:0], 2'b00};
  assign offset   = (kind == KIND_COND) ? shortOff : longOff;
  assign relAddr  = baseAddr + offset;
  assign regAddr  = sprTarget & ALIGN_MASK;

  always_comb begin
    unique case (strobe.src)
      SRC_REL: resolved = relAddr;
      SRC_ABS: resolved = offset;
      SRC_REG: resolved = regAddr;
      default: resolved = seqAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr  <= '0;
      nextTaken <= 1'b0;
      linkAddr  <= '0;
      linkWrite <= 1'b0;
    end else if (strobe.load) begin
      nextAddr  <= resolved;
      nextTaken <= (resolved != seqAddr);
      linkAddr  <= seqAddr;
      linkWrite <= lkBit;
    end else if (strobe.drain) begin
      nextTaken <= 1'b0;
      linkWrite <= 1'b0;
    end
  end
endmodule

// File: rtl/branchUnit.sv
module branchUnit
  import brPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CR_W    = 32,
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 14,
  parameter int BI_W    = $clog2(CR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        opKind,
  input  logic              aaBit,
  input  logic              lkBit,
  input  logic [4:0]        boField,
  input  logic [BI_W-1:0]   biField,
  input  logic [LONG_W-1:0] dispWord,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [CR_W-1:0]   condReg,
  input  logic [ADDR_W-1:0] sprTarget,
  input  logic [ADDR_W-1:0] sprCount,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              nextTaken,
  output logic [ADDR_W-1:0] linkAddr,
  output logic              linkWrite
);
  brKind_t   kindT;
  brStrobe_t strobe;

  assign kindT = brKind_t'(opKind);

  brControl #(
    .CR_W (CR_W),
    .CTR_W(ADDR_W),
    .BI_W (BI_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .kind    (kindT),
    .aaBit   (aaBit),
    .boField (boField),
    .biField (biField),
    .condReg (condReg),
    .sprCount(sprCount),
    .outValid(outValid),
    .outReady(outReady),
    .strobe  (strobe)
  );

  brDatapath #(
    .ADDR_W (ADDR_W),
    .LONG_W (LONG_W),
    .SHORT_W(SHORT_W)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .kind     (kindT),
    .lkBit    (lkBit),
    .instAddr (instAddr),
    .dispWord (dispWord),
    .sprTarget(sprTarget),
    .nextAddr (nextAddr),
    .nextTaken(nextTaken),
    .linkAddr (linkAddr),
    .linkWrite(linkWrite)
  );
endmodule

// File: rtl/brChecker.sv
module brChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              lkBit,
  input logic [ADDR_W-1:0] instAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] nextAddr,
  input logic              nextTaken,
  input logic [ADDR_W-1:0] linkAddr,
  input logic              linkWrite
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(nextAddr) && $stable(linkAddr)
                              && $stable(nextTaken) && $stable(linkWrite));

  assert_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (nextTaken == (nextAddr != linkAddr)));

  assert_link_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> linkWrite == $past(lkBit)
                           && linkAddr == (($past(instAddr) & ALIGN_MASK) + ADDR_W'(4)));

  assert_align_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> nextAddr[1:0] == 2'b00 && linkAddr[1:0] == 2'b00);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !nextTaken && !linkWrite);
endmodule

bind branchUnit brChecker #(.ADDR_W(ADDR_W)) i_brChecker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .lkBit    (lkBit),
  .instAddr (instAddr),
  .outValid (outValid),
  .outReady (outReady),
  .nextAddr (nextAddr),
  .nextTaken(nextTaken),
  .linkAddr (linkAddr),
  .linkWrite(linkWrite)
);

// File: tb/test_branchUnit.sv
`timescale 1ns/1ps
module test_branchUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  opKind = '0;
  logic        aaBit = 1'b0;
  logic        lkBit = 1'b0;
  logic [4:0]  boField = '0;
  logic [4:0]  biField = '0;
  logic [23:0] dispWord = '0;
  logic [31:0] instAddr = '0;
  logic [31:0] condReg = '0;
  logic [31:0] sprTarget = '0;
  logic [31:0] sprCount = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] nextAddr;
  logic        nextTaken;
  logic [31:0] linkAddr;
  logic        linkWrite;

  int checks = 0;
  int fails = 0;
  int readyMode = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [31:0] na;
    logic        tk;
    logic [31:0] la;
    logic        lw;
  } exp_t;

  exp_t  sbq[$];
  string tagQ[$];

  always #4 clk = ~clk;  // 125 MHz

  branchUnit i_branchUnit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opKind(opKind), .aaBit(aaBit), .lkBit(lkBit), .boField(boField),
    .biField(biField), .dispWord(dispWord), .instAddr(instAddr),
    .condReg(condReg), .sprTarget(sprTarget), .sprCount(sprCount),
    .outValid(outValid), .outReady(outReady), .nextAddr(nextAddr),
    .nextTaken(nextTaken), .linkAddr(linkAddr), .linkWrite(linkWrite)
  );

  // independent model written from the requirements
  function automatic exp_t model(input logic [1:0] k, input logic aa, input logic lk,
                                 input logic [4:0] bo, input logic [4:0] bi,
                                 input logic [23:0] d, input logic [31:0] cia,
                                 input logic [31:0] cr, input logic [31:0] tgt,
                                 input logic [31:0] ctr);
    exp_t e;
    logic [31:0] base, seq, off, dest, cnt;
    logic go, ctrPass, condPass;
    base = {cia[31:2], 2'b00};
    seq  = base + 32'd4;
    if (k == 2'd0) begin
      go = 1'b1;
    end else begin
      cnt = ctr - 32'd1;
      if (bo[2]) ctrPass = 1'b1;
      else if (bo[1]) ctrPass = (cnt == 32'd0);
      else ctrPass = (cnt != 32'd0);
      if (bo[4]) condPass = 1'b1;
      else condPass = (cr[31 - bi] == bo[3]);
      go = ctrPass && condPass;
    end
    if (k == 2'd0) off = 32'($signed(d)) << 2;
    else off = 32'($signed(d[13:0])) << 2;
    if (k >= 2'd2) dest = {tgt[31:2], 2'b00};
    else if (aa) dest = off;
    else dest = base + off;
    e.na = go ? dest : seq;
    e.tk = (e.na != seq);
    e.la = seq;
    e.lw = lk;
    return e;
  endfunction

  task automatic send(input string tag, input logic [1:0] k, input logic aa, input logic lk,
                      input logic [4:0] bo, input logic [4:0] bi, input logic [23:0] d,
                      input logic [31:0] cia, input logic [31:0] cr,
                      input logic [31:0] tgt, input logic [31:0] ctr);
    bit ok;
    @(negedge clk);
    opKind = k; aaBit = aa; lkBit = lk; boField = bo; biField = bi;
    dispWord = d; instAddr = cia; condReg = cr; sprTarget = tgt; sprCount = ctr;
    inValid = 1'b1;
    forever begin
      #1;
      ok = inReady;
      if (ok) begin
        sbq.push_back(model(k, aa, lk, bo, bi, d, cia, cr, tgt, ctr));
        tagQ.push_back(tag);
      end
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: sets the consumer's ready, pops and compares the results
  exp_t heldVal;
  bit   held = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (readyMode == 0) outReady = 1'b1;
      else outReady = ($urandom % 3) != 0;
      if (held) begin
        checks++;
        if (!outValid || nextAddr != heldVal.na || nextTaken != heldVal.tk ||
            linkAddr != heldVal.la || linkWrite != heldVal.lw) begin
          fails++;
          $display("FAIL R1 stalled output moved: valid=%0b next=%h expected next=%h",
                   outValid, nextAddr, heldVal.na);
        end
      end
      held = outValid && !outReady;
      heldVal = '{na: nextAddr, tk: nextTaken, la: linkAddr, lw: linkWrite};
      if (!outValid) begin
        checks++;
        if (nextTaken || linkWrite) begin
          fails++;
          $display("FAIL R11 flags while idle: taken=%0b link=%0b expected 0 0",
                   nextTaken, linkWrite);
        end
      end
      if (outValid && outReady) begin
        checks++;
        if (sbq.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result next=%h expected none", nextAddr);
        end else begin
          exp_t e;
          string t;
          e = sbq.pop_front();
          t = tagQ.pop_front();
          if (nextAddr != e.na || nextTaken != e.tk || linkAddr != e.la || linkWrite != e.lw) begin
            fails++;
            $display("FAIL %s: next=%h taken=%0b link=%h lw=%0b expected next=%h taken=%0b link=%h lw=%0b",
                     t, nextAddr, nextTaken, linkAddr, linkWrite, e.na, e.tk, e.la, e.lw);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  localparam logic [4:0] BO_LIST [9] = '{5'd12, 5'd4, 5'd20, 5'd0, 5'd2, 5'd8, 5'd10, 5'd16, 5'd18};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;  // R11 reset state
    if (outValid || nextTaken || linkWrite || !inReady) begin
      fails++;
      $display("FAIL R11 reset state: valid=%0b taken=%0b link=%0b ready=%0b expected 0 0 0 1",
               outValid, nextTaken, linkWrite, inReady);
    end

    // R2 unconditional forms
    send("R2 rel",     2'd0, 0, 0, 5'd0, 5'd0, 24'd100,      32'h0000_1000, 0, 0, 0);
    send("R2 abs",     2'd0, 1, 0, 5'd0, 5'd0, 24'd100,      32'h0000_1000, 0, 0, 0);
    send("R9 rel+lk",  2'd0, 0, 1, 5'd0, 5'd0, 24'hFF_FFF0,  32'h0000_2000, 0, 0, 0);
    send("R9 abs+lk",  2'd0, 1, 1, 5'd0, 5'd0, 24'h80_0000,  32'h0000_2000, 0, 0, 0);
    // R8 target equals sequential address
    send("R8 rel seq", 2'd0, 0, 0, 5'd0, 5'd0, 24'd1,        32'h0000_3000, 0, 0, 0);
    send("R8 abs seq", 2'd0, 1, 1, 5'd0, 5'd0, 24'h00_0C01,  32'h0000_3000, 0, 0, 0);
    // R4 condition bit tests
    send("R4 set hit",    2'd1, 0, 0, 5'd12, 5'd0,  24'd8, 32'h100, 32'h8000_0000, 0, 0);
    send("R4 set miss",   2'd1, 0, 0, 5'd12, 5'd31, 24'd8, 32'h100, 32'h8000_0000, 0, 0);
    send("R4 clear hit",  2'd1, 0, 0, 5'd4,  5'd31, 24'd8, 32'h100, 32'hFFFF_FFFE, 0, 0);
    send("R4 clear miss", 2'd1, 0, 1, 5'd4,  5'd0,  24'd8, 32'h100, 32'hFFFF_FFFE, 0, 0);
    send("R4 always",     2'd1, 0, 0, 5'd20, 5'd7,  24'd8, 32'h100, 32'h0, 0, 0);
    // R3 short displacement, upper bits ignored, negative
    send("R3 neg short",  2'd1, 0, 0, 5'd20, 5'd0, 24'hAB_3FFF, 32'h8000, 0, 0, 0);
    send("R3 abs short",  2'd1, 1, 0, 5'd20, 5'd0, 24'h55_2000, 32'h8000, 0, 0, 0);
    // R5 counter forms at boundary counts 0, 1 and 5
    for (int b = 3; b < 9; b++) begin
      send("R5 ctr=1", 2'd1, 0, 0, BO_LIST[b], 5'd3, 24'd16, 32'h400, 32'h1000_0000, 0, 32'd1);
      send("R5 ctr=5", 2'd1, 0, 0, BO_LIST[b], 5'd3, 24'd16, 32'h400, 32'h0, 0, 32'd5);
      send("R5 ctr=0", 2'd1, 0, 0, BO_LIST[b], 5'd3, 24'd16, 32'h400, 32'h1000_0000, 0, 32'd0);
    end
    // R6 register targets
    send("R6 link reg",   2'd2, 1, 1, 5'd20, 5'd0, 24'hFF_FFFF, 32'h500, 0, 32'h1234_567F, 0);
    send("R6 target reg", 2'd3, 0, 0, 5'd12, 5'd1, 24'd3,       32'h500, 32'h4000_0000, 32'hCAFE_0002, 0);
    send("R7 reg miss",   2'd3, 0, 0, 5'd12, 5'd1, 24'd3,       32'h500, 32'h0, 32'hCAFE_0002, 0);
    // R10 unaligned instruction address
    send("R10 unaligned", 2'd0, 0, 1, 5'd0, 5'd0, 24'd2, 32'h0000_0603, 0, 0, 0);
    send("R10 seq unal",  2'd1, 0, 0, 5'd12, 5'd0, 24'd2, 32'h0000_0702, 0, 0, 0);
    idle();
    repeat (4) @(posedge clk);

    // R1 back-pressure with a random mix
    readyMode = 1;
    for (int n = 0; n < 300; n++) begin
      send("R1 random mix", 2'($urandom), 1'($urandom), 1'($urandom), BO_LIST[$urandom % 9],
           5'($urandom), 24'($urandom), $urandom, $urandom, $urandom, 32'($urandom % 4));
      if ((n % 7) == 0) idle();
    end
    idle();
    readyMode = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    #1;
    checks++;
    if (sbq.size() != 0 || outValid) begin
      fails++;
      $display("FAIL R1 results left: queue=%0d valid=%0b expected 0 0", sbq.size(), outValid);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule